// File: doc/BRIEF.md
# Online-Testable Controlled-Swap 2-to-4 Decoder

This block turns a 2-bit select into four one-hot lines, using three controlled-swap gates as its only logic. Each gate sits inside a self-checking cell. The entry stage of the cell computes the gate outputs and also an entry parity: the parity of the gate inputs, XORed with a seed bit. The exit stage passes those outputs on unchanged and computes an exit parity from what it actually receives, using the same seed. A controlled swap preserves parity, so in a healthy cell the two parities are equal.

A final test stage collects all six parity bits, passes them through, and XORs them together with a check bit to form one error flag. The flag is produced while the decoder is doing normal work, not in a separate test mode. For verification, a fault-injection bus lets any output bit of any gate be flipped between that gate's two stages. The decoded lines, the parity bits and the flag are registered once, with a synchronous active-low reset, so every result appears one clock after its inputs.

Top module: `rdec_online_decoder`

## Requirements
- R1: With `en` high and no injected fault, `dec_out` is one-hot and bit `dec_out[sel]` is set, where `sel[1]` is the high select bit and `sel[0]` the low one.
- R2: With `en` low, `dec_out` is all zeros whatever `sel`, the seed, the check bit or the fault bus hold.
- R3: With no injected fault, each parity pair matches: `par_out[2k]` (entry parity of gate k+1) equals `par_out[2k+1]` (exit parity of gate k+1), for k = 0, 1, 2.
- R4: With no fault and seed s, the entry parities are as follows. Gate 1 gives `~sel[1]^s`. Gate 2 gives `sel[1]^sel[0]^s`. Gate 3 gives `~(sel[1]^sel[0])^s`. For example, with select 10 and seed 0, `par_out[5:0]` read from bit 0 upward is 0,0,1,1,0,0.
- R5: With no injected fault, `err` equals the check input `chk`.
- R6: With exactly one bit of `fault_mask` set, `err` equals `~chk`. Bit `fault_mask[3k+j]` flips output j of gate k+1: j=0 is the control copy, j=1 the first swapped line, j=2 the second.
- R7: With exactly one bit set in the slice of gate k+1, the parity pair of that gate differs and the pairs of the other two gates still match.
- R8: Outputs are registered. A low `rst_n` at a clock edge clears `dec_out`, `par_out` and `err` to zero. Otherwise each output reflects the inputs present at the previous edge.
- R9: Two fault bits set within the slice of the same gate leave `err` equal to `chk`. This is the coverage limit of a parity check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 2 | Select code; bit 1 is the high bit |
| en | input | 1 | Enables the decoded lines |
| par_seed | input | 1 | Seed driven into both parity stages of every cell |
| chk | input | 1 | Check bit folded into the error flag |
| fault_mask | input | 9 | Per-gate fault injection, three bits per gate |
| dec_out | output | 4 | Registered one-hot decoded lines |
| par_out | output | 6 | Registered parity bits, entry/exit pair per gate |
| err | output | 1 | Registered error flag |

## Verification
The decode and parity-match properties assume that the fault bus was all zeros in the previous cycle. The fault properties count the set bits of the previous cycle's mask, because results appear one clock after their inputs. The properties are armed only once the edge before has seen reset released. The stimulus changes every input on the falling clock edge and holds it for a whole cycle. It moves the fault bus only in the scenarios meant to exercise it, so the fault-free checks always see a clean mask.

// File: rtl/rdec_pkg.sv
// Shared sizes and types for the online-testable decoder.
// Assumes the controlled-swap gate has three lines: control, first and second data.
package rdec_pkg;
    localparam int unsigned GATE_CNT = 3;
    localparam int unsigned GATE_W   = 3;
    localparam int unsigned PAR_W    = 2 * GATE_CNT;
    localparam int unsigned MASK_W   = GATE_CNT * GATE_W;
    localparam int unsigned SEL_W    = 2;
    localparam int unsigned LINE_CNT = 1 << SEL_W;

    typedef logic [GATE_W-1:0] gate_vec_t;
endpackage

// File: rtl/rdec_swap_stage.sv
// Entry stage of a testable cell: a controlled swap plus an entry parity.
// The entry parity is taken from the gate inputs. A swap keeps the number of ones
// unchanged, so this parity equals the parity of the outputs when the stage is healthy.
// Line 0 is the control. When it is 1, lines 1 and 2 trade places.
module rdec_swap_stage
    import rdec_pkg::*;
(
    input  gate_vec_t din,
    input  logic      seed,
    output gate_vec_t dout,
    output logic      par
);
    // Purpose: controlled swap of the two data lines.
    always_comb begin
        dout[0] = din[0];
        dout[1] = (~din[0] & din[1]) | (din[0] & din[2]);
        dout[2] = (~din[0] & din[2]) | (din[0] & din[1]);
    end

    // Purpose: entry parity from the inputs and the seed.
    assign par = (^din) ^ seed;
endmodule

// File: rtl/rdec_pass_stage.sv
// Exit stage of a testable cell: an identity gate with its own parity.
// The data passes through unchanged. The parity covers the values actually received.
module rdec_pass_stage
    import rdec_pkg::*;
(
    input  gate_vec_t din,
    input  logic      seed,
    output gate_vec_t dout,
    output logic      par
);
    // Purpose: pass-through of the data lines.
    assign dout = din;
    // Purpose: exit parity over the received lines and the seed.
    assign par  = (^din) ^ seed;
endmodule

// File: rtl/rdec_testable_cell.sv
// Wraps one controlled-swap gate: entry stage, fault-injection point, exit stage.
// Assumes both stages get the same seed, so that in a healthy cell the two parities match.
module rdec_testable_cell
    import rdec_pkg::*;
(
    input  gate_vec_t din,
    input  logic      seed,
    input  gate_vec_t fmask,
    output gate_vec_t dout,
    output logic      par_entry,
    output logic      par_exit
);
    gate_vec_t swap_q;
    gate_vec_t link;

    rdec_swap_stage u_swap (
        .din  (din),
        .seed (seed),
        .dout (swap_q),
        .par  (par_entry)
    );

    // Purpose: inject a fault between the two stages.
    assign link = swap_q ^ fmask;

    rdec_pass_stage u_pass (
        .din  (link),
        .seed (seed),
        .dout (dout),
        .par  (par_exit)
    );
endmodule

// File: rtl/rdec_test_cell.sv
// Collects the parity bits, passes them through, and folds them with the check bit.
// Assumes the parities arrive as matched pairs, so a healthy circuit leaves the flag equal to chk.
module rdec_test_cell #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] par_in,
    input  logic         chk,
    output logic [W-1:0] par_thru,
    output logic         flag
);
    // Purpose: pass-through of the parity lines.
    assign par_thru = par_in;
    // Purpose: error flag as the XOR of every line and the check bit.
    assign flag     = (^par_in) ^ chk;
endmodule

// File: rtl/rdec_online_decoder.sv
// Top of the online-testable 2-to-4 decoder.
// Gate 1 takes (I1, 1, 0) and so produces both I1' and I1.
// Gate 2 takes (I2, I1, 0); gate 3 takes (I2, I1', 0).
// The swapped lines of gates 2 and 3 are the four decoded lines.
// The outputs are registered once, with a synchronous active-low reset.
module rdec_online_decoder
    import rdec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    sel,
    input  logic                en,
    input  logic                par_seed,
    input  logic                chk,
    input  logic [MASK_W-1:0]   fault_mask,
    output logic [LINE_CNT-1:0] dec_out,
    output logic [PAR_W-1:0]    par_out,
    output logic                err
);
    gate_vec_t            g_in  [GATE_CNT];
    gate_vec_t            g_out [GATE_CNT];
    logic [PAR_W-1:0]     par_raw;
    logic [PAR_W-1:0]     par_thru;
    logic                 flag;
    logic [LINE_CNT-1:0]  lines;

    // Purpose: wire the gate inputs; sel[1] is I1 and sel[0] is I2.
    always_comb begin
        g_in[0] = {1'b0, 1'b1, sel[1]};
        g_in[1] = {1'b0, g_out[0][2], sel[0]};
        g_in[2] = {1'b0, g_out[0][1], sel[0]};
    end

    for (genvar k = 0; k < GATE_CNT; k++) begin : g_cell
        rdec_testable_cell u_cell (
            .din       (g_in[k]),
            .seed      (par_seed),
            .fmask     (fault_mask[k*GATE_W +: GATE_W]),
            .dout      (g_out[k]),
            .par_entry (par_raw[2*k]),
            .par_exit  (par_raw[2*k+1])
        );
    end

    rdec_test_cell #(.W(PAR_W)) u_tc (
        .par_in   (par_raw),
        .chk      (chk),
        .par_thru (par_thru),
        .flag     (flag)
    );

    // Purpose: map the swapped lines of gates 2 and 3 onto the select index.
    always_comb begin
        lines[3] = g_out[1][2];
        lines[2] = g_out[1][1];
        lines[1] = g_out[2][2];
        lines[0] = g_out[2][1];
    end

    // Purpose: output register with enable gating and synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_out <= '0;
            par_out <= '0;
            err     <= 1'b0;
        end else begin
            dec_out <= en ? lines : '0;
            par_out <= par_thru;
            err     <= flag;
        end
    end
endmodule

// File: rtl/rdec_online_decoder_chk.sv
// Checker bound to the decoder top. It relates the registered outputs to the inputs of the previous edge.
module rdec_online_decoder_chk
    import rdec_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [SEL_W-1:0]    sel,
    input logic                en,
    input logic                chk,
    input logic [MASK_W-1:0]   fault_mask,
    input logic [LINE_CNT-1:0] dec_out,
    input logic [PAR_W-1:0]    par_out,
    input logic                err
);
    logic armed   = 1'b0;
    logic started = 1'b0;

    // Purpose: note whether reset was released at the previous edge.
    always_ff @(posedge clk) begin
        armed   <= rst_n;
        started <= 1'b1;
    end

    AST_DEC_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(en) && ($past(fault_mask) == '0)
        |-> ($countones(dec_out) == 1) && dec_out[$past(sel)]); // R1

    AST_EN_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(en) |-> dec_out == '0); // R2

    AST_PAIRS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(fault_mask) == '0)
        |-> (par_out[0] == par_out[1]) && (par_out[2] == par_out[3])
            && (par_out[4] == par_out[5])); // R3

    AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(fault_mask) == '0) |-> err == $past(chk)); // R5

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($countones($past(fault_mask)) == 1) |-> err != $past(chk)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        started && !$past(rst_n) |-> (dec_out == '0) && (par_out == '0) && !err); // R8
endmodule

bind rdec_online_decoder rdec_online_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .en         (en),
    .chk        (chk),
    .fault_mask (fault_mask),
    .dec_out    (dec_out),
    .par_out    (par_out),
    .err        (err)
);

// File: tb/rdec_online_decoder_bench.sv
// Directed bench: one task per scenario. Inputs change on the falling edge; outputs are sampled one falling edge later.
module rdec_online_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] sel;
    logic       en;
    logic       par_seed;
    logic       chk;
    logic [8:0] fault_mask;
    logic [3:0] dec_out;
    logic [5:0] par_out;
    logic       err;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rdec_online_decoder u_rdec_online_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .en         (en),
        .par_seed   (par_seed),
        .chk        (chk),
        .fault_mask (fault_mask),
        .dec_out    (dec_out),
        .par_out    (par_out),
        .err        (err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] s, input logic e, input logic sd,
                         input logic c, input logic [8:0] m);
        @(negedge clk);
        sel = s; en = e; par_seed = sd; chk = c; fault_mask = m;
        @(negedge clk);
    endtask

    // Expected parity vector (R4): entry/exit pair per gate.
    function automatic logic [5:0] exp_par(input logic [1:0] s, input logic sd);
        logic p1, p2, p3;
        p1 = ~s[1] ^ sd;
        p2 = s[1] ^ s[0] ^ sd;
        p3 = ~(s[1] ^ s[0]) ^ sd;
        return {p3, p3, p2, p2, p1, p1};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        apply(2'b11, 1'b1, 1'b1, 1'b1, 9'h1);
        check("R8 reset dec", {28'd0, dec_out}, 32'd0);
        check("R8 reset par", {26'd0, par_out}, 32'd0);
        check("R8 reset err", {31'd0, err}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_decode();
        for (int sd = 0; sd < 2; sd++) begin
            for (int s = 0; s < 4; s++) begin
                apply(s[1:0], 1'b1, sd[0], 1'b0, 9'h0);
                check("R1 decode", {28'd0, dec_out}, 32'd1 << s);
                check("R4 parity", {26'd0, par_out}, {26'd0, exp_par(s[1:0], sd[0])});
                check("R3 pairs", {29'd0, par_out[0] ^ par_out[1], par_out[2] ^ par_out[3],
                                   par_out[4] ^ par_out[5]}, 32'd0);
                check("R5 clean err", {31'd0, err}, 32'd0);
            end
        end
    endtask

    task automatic t_stated_example();
        apply(2'b10, 1'b1, 1'b0, 1'b0, 9'h0);
        check("R4 select 10 vector", {26'd0, par_out}, 32'b001100);
        check("R1 select 10 line", {28'd0, dec_out}, 32'b0100);
    endtask

    task automatic t_disabled();
        for (int s = 0; s < 4; s++) begin
            apply(s[1:0], 1'b0, s[0], s[1], 9'h0);
            check("R2 disabled", {28'd0, dec_out}, 32'd0);
        end
        apply(2'b01, 1'b0, 1'b1, 1'b0, 9'h1FF);
        check("R2 disabled with faults", {28'd0, dec_out}, 32'd0);
    endtask

    task automatic t_check_bit();
        apply(2'b01, 1'b1, 1'b1, 1'b1, 9'h0);
        check("R5 chk high", {31'd0, err}, 32'd1);
        check("R1 with chk high", {28'd0, dec_out}, 32'b0010);
    endtask

    task automatic t_single_faults();
        for (int b = 0; b < 9; b++) begin
            for (int s = 0; s < 4; s++) begin
                logic [2:0] mis;
                apply(s[1:0], 1'b1, s[0], b[0], 9'h1 << b);
                check("R6 single fault err", {31'd0, err}, {31'd0, ~b[0]});
                mis = {par_out[4] ^ par_out[5], par_out[2] ^ par_out[3], par_out[0] ^ par_out[1]};
                check("R7 faulty pair only", {29'd0, mis}, 32'd1 << (b / 3));
            end
        end
    endtask

    task automatic t_double_faults();
        for (int g = 0; g < 3; g++) begin
            apply(2'b10, 1'b1, 1'b0, 1'b0, 9'h3 << (3 * g));
            check("R9 double fault same gate", {31'd0, err}, 32'd0);
            apply(2'b01, 1'b1, 1'b1, 1'b1, 9'h5 << (3 * g));
            check("R9 double fault chk high", {31'd0, err}, 32'd1);
        end
    endtask

    task automatic t_latency();
        apply(2'b00, 1'b1, 1'b0, 1'b0, 9'h0);
        @(negedge clk);
        sel = 2'b11;
        #1;
        check("R8 output holds until edge", {28'd0, dec_out}, 32'b0001);
        @(negedge clk);
        check("R8 output after edge", {28'd0, dec_out}, 32'b1000);
    endtask

    initial begin
        sel = 2'b00; en = 1'b0; par_seed = 1'b0; chk = 1'b0; fault_mask = '0;
        rst_n = 1'b0;
        t_reset();
        t_stated_example();
        t_decode();
        t_disabled();
        t_check_bit();
        t_single_faults();
        t_double_faults();
        t_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule